// File: doc/BRIEF.md
# Compare Instruction Byte-Stream Decoder

This block watches an instruction byte stream, taking at most one byte per clock, and picks out the integer compare forms. It classifies the opcode byte, fetches a ModRM byte where the form needs one and checks its middle field, and gathers any immediate bytes. When the last byte of an instruction arrives, it publishes a decoded record. The record carries the operand size, whether an immediate is present, the immediate widened to the operand width, which operand comes first, and the register and r/m selectors.

A mode input picks the default operand width for the non-byte forms: 16 or 32 bits. Only register-to-register forms are supported. A ModRM byte that names memory is reported as unsupported. Bytes that are not compare opcodes, and group opcodes with the wrong extension field, are reported as invalid. After any outcome the decoder waits for a new opcode byte. Prefixes, displacement, SIB bytes and execution are handled elsewhere.

Top module: `cmp_stream_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, all outcome pulses are cleared and the record outputs go to zero. The first accepted byte after reset is treated as an opcode, even if an instruction was cut off part-way.
- R2: Opcode 0x3C takes one immediate byte and no ModRM. It decodes with `dec_size`=0 (8-bit), `dec_accum`=1, `dec_rm_first`=1, `dec_rm_sel`=0, `dec_reg_sel`=0, and the byte in `dec_imm[7:0]` with zeros above.
- R3: Opcode 0x3D takes 4 immediate bytes when `wide_mode`=1 (`dec_size`=2) and 2 bytes when `wide_mode`=0 (`dec_size`=1). Immediate bytes arrive least significant first. `wide_mode` is sampled only with the opcode byte. `dec_size` never reads 3.
- R4: Opcodes 0x80, 0x81 and 0x83 are compares only when ModRM bits [5:3] equal 7 and bits [7:6] equal 3. `dec_rm_sel` is ModRM[2:0], `dec_reg_sel`=0, and `dec_rm_first`=1. The immediate is 1 byte for 0x80 (8-bit), a full operand width for 0x81, and 1 byte for 0x83.
- R5: A 1-byte immediate with a 16- or 32-bit operand (0x83) is sign-extended to the operand width. Bits of `dec_imm` above the operand width are always zero.
- R6: Opcodes 0x38/0x3A are 8-bit and 0x39/0x3B use the mode width. None of them has an immediate. `dec_reg_sel` is ModRM[5:3] and `dec_rm_sel` is ModRM[2:0]. `dec_rm_first` is 1 for 0x38/0x39 and 0 for 0x3A/0x3B.
- R7: A group opcode (0x80/0x81/0x83) whose ModRM[5:3] is not 7 gives a one-cycle `dec_invalid` in the cycle after the ModRM byte. No record is published, and the next byte is an opcode.
- R8: Any opcode byte not listed in R2–R6 gives a one-cycle `dec_invalid` in the cycle after it. The next byte is again an opcode.
- R9: A ModRM with bits [7:6] not equal to 3, on an otherwise valid form, gives a one-cycle `dec_unsup` in the cycle after it, with no record. The next byte is an opcode.
- R10: `dec_valid` is high for exactly the one cycle after the final byte is accepted. Cycles with `byte_valid` low have no effect: the byte value is ignored and no outcome pulse follows. At most one of `dec_valid`, `dec_invalid`, `dec_unsup` is high at a time.
- R11: A record with no immediate has `dec_has_imm`=0 and `dec_imm`=0. Forms with an immediate have `dec_has_imm`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | Default operand width: 1 = 32-bit, 0 = 16-bit |
| byte_valid | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Instruction stream byte |
| dec_valid | output | 1 | One-cycle pulse: the record outputs hold a decoded compare |
| dec_invalid | output | 1 | One-cycle pulse: bad opcode or bad group extension |
| dec_unsup | output | 1 | One-cycle pulse: memory-form ModRM |
| dec_size | output | 2 | Operand size: 0 = 8, 1 = 16, 2 = 32 bits |
| dec_has_imm | output | 1 | Second operand is an immediate |
| dec_imm | output | 32 | Immediate widened to the operand width |
| dec_rm_first | output | 1 | 1: the r/m (or accumulator) operand is first |
| dec_accum | output | 1 | Accumulator short form |
| dec_reg_sel | output | 3 | Register field selector |
| dec_rm_sel | output | 3 | r/m register selector |

## Verification
The stream sends every compare opcode in both width modes. Immediates are chosen with the sign bit set and clear, so that sign extension can be told apart from zero filling and from missing clipping of the upper bits. ModRM bytes use distinct reg and r/m values, which exposes swapped or mis-sliced selectors and a wrong operand order. Bad extension fields, foreign opcodes and memory-form ModRM bytes are each followed at once by a good instruction, to show that the decoder returns to opcode-wait. A stream with idle gaps, a mode change part-way through an instruction, and a reset in the middle of an immediate checks that byte counting and mode capture are tied to accepted bytes only.

// File: rtl/cmpdec_pkg.sv
// Shared constants and types for the compare-instruction stream decoder.
// Assumes byte-wide stream and a maximum operand width that is a multiple of 8.
package cmpdec_pkg;

    localparam int BYTE_W     = 8;
    localparam int OPR_W      = 32;
    localparam int IMM_LANES  = OPR_W / BYTE_W;
    localparam int HALF_LANES = IMM_LANES / 2;
    localparam int LANE_W     = $clog2(IMM_LANES);
    localparam int IMMC_W     = $clog2(IMM_LANES + 1);

    // Opcode bytes recognised as compare forms
    localparam logic [BYTE_W-1:0] OPC_RM_R8   = 8'h38;
    localparam logic [BYTE_W-1:0] OPC_RM_RV   = 8'h39;
    localparam logic [BYTE_W-1:0] OPC_R_RM8   = 8'h3A;
    localparam logic [BYTE_W-1:0] OPC_R_RMV   = 8'h3B;
    localparam logic [BYTE_W-1:0] OPC_ACC_I8  = 8'h3C;
    localparam logic [BYTE_W-1:0] OPC_ACC_IV  = 8'h3D;
    localparam logic [BYTE_W-1:0] OPC_GRP_I8  = 8'h80;
    localparam logic [BYTE_W-1:0] OPC_GRP_IV  = 8'h81;
    localparam logic [BYTE_W-1:0] OPC_GRP_IS8 = 8'h83;

    localparam logic [2:0] GRP_CMP_EXT = 3'd7;
    localparam logic [1:0] MOD_REGREG  = 2'd3;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2
    } opsize_e;

    typedef enum logic [1:0] {
        ST_OPC   = 2'd0,
        ST_MODRM = 2'd1,
        ST_IMM   = 2'd2
    } dstate_e;

    typedef struct packed {
        logic              known;
        logic              group;
        logic              needs_modrm;
        opsize_e           size;
        logic [IMMC_W-1:0] imm_bytes;
        logic              rm_first;
        logic              accum;
    } opinfo_t;

endpackage

// File: rtl/cmpdec_opclass.sv
// Opcode classifier: purely combinational map from an opcode byte and the
// width mode to the form descriptor. Assumes the byte is an opcode; the
// caller decides when that is true.
module cmpdec_opclass
    import cmpdec_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    input  logic              wide_mode,
    output opinfo_t           info
);

    opsize_e           mode_size;
    logic [IMMC_W-1:0] mode_bytes;

    // Width chosen by the mode for the non-byte forms
    always_comb begin
        mode_size  = wide_mode ? SZ32 : SZ16;
        mode_bytes = wide_mode ? IMMC_W'(IMM_LANES) : IMMC_W'(HALF_LANES);
    end

    // Form table
    always_comb begin
        info = '0;
        unique case (opc)
            OPC_ACC_I8: begin
                info.known     = 1'b1;
                info.size      = SZ8;
                info.imm_bytes = IMMC_W'(1);
                info.rm_first  = 1'b1;
                info.accum     = 1'b1;
            end
            OPC_ACC_IV: begin
                info.known     = 1'b1;
                info.size      = mode_size;
                info.imm_bytes = mode_bytes;
                info.rm_first  = 1'b1;
                info.accum     = 1'b1;
            end
            OPC_GRP_I8: begin
                info.known       = 1'b1;
                info.group       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = SZ8;
                info.imm_bytes   = IMMC_W'(1);
                info.rm_first    = 1'b1;
            end
            OPC_GRP_IV: begin
                info.known       = 1'b1;
                info.group       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = mode_size;
                info.imm_bytes   = mode_bytes;
                info.rm_first    = 1'b1;
            end
            OPC_GRP_IS8: begin
                info.known       = 1'b1;
                info.group       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = mode_size;
                info.imm_bytes   = IMMC_W'(1);
                info.rm_first    = 1'b1;
            end
            OPC_RM_R8: begin
                info.known       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = SZ8;
                info.rm_first    = 1'b1;
            end
            OPC_RM_RV: begin
                info.known       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = mode_size;
                info.rm_first    = 1'b1;
            end
            OPC_R_RM8: begin
                info.known       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = SZ8;
            end
            OPC_R_RMV: begin
                info.known       = 1'b1;
                info.needs_modrm = 1'b1;
                info.size        = mode_size;
            end
            default: info = '0;
        endcase
    end

endmodule

// File: rtl/cmpdec_immcollect.sv
// Immediate assembler: one register lane per stream byte, written at the
// lane index the controller supplies. The merged output already contains
// the byte being written this cycle so the final value is ready at once.
// Assumes clear and write are never requested in the same cycle.
module cmpdec_immcollect
    import cmpdec_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr,
    input  logic [LANE_W-1:0]         lane,
    input  logic [BYTE_W-1:0]         din,
    output logic [IMM_LANES*BYTE_W-1:0] merged
);

    for (genvar g = 0; g < IMM_LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        logic              hit;

        assign hit = wr && (lane == LANE_W'(g));

        // Hold this lane's byte; cleared at each new opcode
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q <= '0;
            end else if (hit) begin
                lane_q <= din;
            end
        end

        assign merged[g*BYTE_W +: BYTE_W] = hit ? din : lane_q;
    end

endmodule

// File: rtl/cmpdec_ctrl.sv
// Sequencer: walks opcode, ModRM and immediate phases, counts remaining
// immediate bytes, and registers the outcome pulses and decoded record.
// Assumes one byte per cycle at most, qualified by byte_valid.
module cmpdec_ctrl
    import cmpdec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_valid,
    input  logic [BYTE_W-1:0]    byte_in,
    input  opinfo_t              op_info,
    input  logic [OPR_W-1:0]     imm_merged,
    output logic                 imm_clr,
    output logic                 imm_wr,
    output logic [LANE_W-1:0]    imm_lane,
    output logic                 dec_valid,
    output logic                 dec_invalid,
    output logic                 dec_unsup,
    output logic [1:0]           dec_size,
    output logic                 dec_has_imm,
    output logic [OPR_W-1:0]     dec_imm,
    output logic                 dec_rm_first,
    output logic                 dec_accum,
    output logic [2:0]           dec_reg_sel,
    output logic [2:0]           dec_rm_sel
);

    dstate_e           state_q;
    opinfo_t           info_q;
    logic [IMMC_W-1:0] cnt_q;
    logic [LANE_W-1:0] lane_q;
    logic [2:0]        reg_q;
    logic [2:0]        rm_q;

    logic [1:0]        mr_mod;
    logic [2:0]        mr_ext;
    logic [2:0]        mr_rm;
    logic              mr_bad_ext;
    logic              mr_mem;
    logic              fire;
    logic              pub_has;
    logic [2:0]        pub_reg;
    logic [2:0]        pub_rm;
    logic [OPR_W-1:0]  pub_imm;

    // Sign-extend the collected immediate to the operand width, zero above
    function automatic logic [OPR_W-1:0] widen_imm(
        input logic [OPR_W-1:0]  raw,
        input logic [IMMC_W-1:0] nbytes,
        input opsize_e           sz
    );
        int               src_bits;
        int               dst_bits;
        logic             sgn;
        logic [OPR_W-1:0] res;
        src_bits = int'(nbytes) * BYTE_W;
        case (sz)
            SZ8:     dst_bits = BYTE_W;
            SZ16:    dst_bits = 2 * BYTE_W;
            default: dst_bits = OPR_W;
        endcase
        if (nbytes == IMMC_W'(1)) begin
            sgn = raw[BYTE_W-1];
        end else if (nbytes == IMMC_W'(HALF_LANES)) begin
            sgn = raw[HALF_LANES*BYTE_W-1];
        end else begin
            sgn = raw[OPR_W-1];
        end
        res = '0;
        for (int i = 0; i < OPR_W; i++) begin
            if (i < dst_bits) begin
                res[i] = (i < src_bits) ? raw[i] : sgn;
            end
        end
        return res;
    endfunction

    // ModRM field slicing and checks
    always_comb begin
        mr_mod     = byte_in[7:6];
        mr_ext     = byte_in[5:3];
        mr_rm      = byte_in[2:0];
        mr_bad_ext = info_q.group && (mr_ext != GRP_CMP_EXT);
        mr_mem     = (mr_mod != MOD_REGREG);
    end

    // Collector controls
    always_comb begin
        imm_clr  = byte_valid && (state_q == ST_OPC);
        imm_wr   = byte_valid && (state_q == ST_IMM);
        imm_lane = lane_q;
    end

    // Record to publish if this byte completes the instruction
    always_comb begin
        fire    = 1'b0;
        pub_has = 1'b0;
        pub_reg = reg_q;
        pub_rm  = rm_q;
        pub_imm = '0;
        if (byte_valid && state_q == ST_MODRM) begin
            fire    = !mr_bad_ext && !mr_mem && (info_q.imm_bytes == '0);
            pub_reg = info_q.group ? 3'd0 : mr_ext;
            pub_rm  = mr_rm;
        end else if (byte_valid && state_q == ST_IMM) begin
            fire    = (cnt_q == IMMC_W'(1));
            pub_has = 1'b1;
            pub_imm = widen_imm(imm_merged, info_q.imm_bytes, info_q.size);
        end
    end

    // Phase sequencing and byte counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPC;
            info_q  <= '0;
            cnt_q   <= '0;
            lane_q  <= '0;
            reg_q   <= '0;
            rm_q    <= '0;
        end else if (byte_valid) begin
            unique case (state_q)
                ST_OPC: begin
                    if (op_info.known) begin
                        info_q  <= op_info;
                        cnt_q   <= op_info.imm_bytes;
                        lane_q  <= '0;
                        reg_q   <= '0;
                        rm_q    <= '0;
                        state_q <= op_info.needs_modrm ? ST_MODRM : ST_IMM;
                    end
                end
                ST_MODRM: begin
                    if (mr_bad_ext || mr_mem || info_q.imm_bytes == '0) begin
                        state_q <= ST_OPC;
                    end else begin
                        reg_q   <= info_q.group ? 3'd0 : mr_ext;
                        rm_q    <= mr_rm;
                        state_q <= ST_IMM;
                    end
                end
                ST_IMM: begin
                    if (cnt_q == IMMC_W'(1)) begin
                        state_q <= ST_OPC;
                    end else begin
                        cnt_q  <= cnt_q - 1'b1;
                        lane_q <= lane_q + 1'b1;
                    end
                end
                default: state_q <= ST_OPC;
            endcase
        end
    end

    // Outcome pulses, one cycle each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            dec_invalid <= 1'b0;
            dec_unsup   <= 1'b0;
        end else begin
            dec_valid   <= fire;
            dec_invalid <= byte_valid &&
                           (((state_q == ST_OPC) && !op_info.known) ||
                            ((state_q == ST_MODRM) && mr_bad_ext));
            dec_unsup   <= byte_valid && (state_q == ST_MODRM) &&
                           !mr_bad_ext && mr_mem;
        end
    end

    // Decoded record, updated only when an instruction completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_size     <= '0;
            dec_has_imm  <= 1'b0;
            dec_imm      <= '0;
            dec_rm_first <= 1'b0;
            dec_accum    <= 1'b0;
            dec_reg_sel  <= '0;
            dec_rm_sel   <= '0;
        end else if (fire) begin
            dec_size     <= info_q.size;
            dec_has_imm  <= pub_has;
            dec_imm      <= pub_imm;
            dec_rm_first <= info_q.rm_first;
            dec_accum    <= info_q.accum;
            dec_reg_sel  <= pub_reg;
            dec_rm_sel   <= pub_rm;
        end
    end

endmodule

// File: rtl/cmp_stream_decoder.sv
// Top level of the compare-instruction stream decoder: ties the opcode
// classifier, immediate assembler and sequencer together.
// Assumes prefixes are removed upstream and only register forms matter.
module cmp_stream_decoder
    import cmpdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    output logic              dec_valid,
    output logic              dec_invalid,
    output logic              dec_unsup,
    output logic [1:0]        dec_size,
    output logic              dec_has_imm,
    output logic [31:0]       dec_imm,
    output logic              dec_rm_first,
    output logic              dec_accum,
    output logic [2:0]        dec_reg_sel,
    output logic [2:0]        dec_rm_sel
);

    opinfo_t           op_info;
    logic              imm_clr;
    logic              imm_wr;
    logic [LANE_W-1:0] imm_lane;
    logic [OPR_W-1:0]  imm_merged;

    cmpdec_opclass u_opclass (
        .opc       (byte_in),
        .wide_mode (wide_mode),
        .info      (op_info)
    );

    cmpdec_immcollect u_imm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (imm_clr),
        .wr     (imm_wr),
        .lane   (imm_lane),
        .din    (byte_in),
        .merged (imm_merged)
    );

    cmpdec_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid),
        .byte_in      (byte_in),
        .op_info      (op_info),
        .imm_merged   (imm_merged),
        .imm_clr      (imm_clr),
        .imm_wr       (imm_wr),
        .imm_lane     (imm_lane),
        .dec_valid    (dec_valid),
        .dec_invalid  (dec_invalid),
        .dec_unsup    (dec_unsup),
        .dec_size     (dec_size),
        .dec_has_imm  (dec_has_imm),
        .dec_imm      (dec_imm),
        .dec_rm_first (dec_rm_first),
        .dec_accum    (dec_accum),
        .dec_reg_sel  (dec_reg_sel),
        .dec_rm_sel   (dec_rm_sel)
    );

endmodule

// File: rtl/cmpdec_chk.sv
// Property checker for the compare decoder, attached by bind.
// Assumes the port encodings stated in the brief.
module cmpdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_valid,
    input logic        dec_valid,
    input logic        dec_invalid,
    input logic        dec_unsup,
    input logic [1:0]  dec_size,
    input logic        dec_has_imm,
    input logic [31:0] dec_imm,
    input logic        dec_rm_first,
    input logic        dec_accum,
    input logic [2:0]  dec_rm_sel
);

    p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_outcome_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_valid, dec_invalid, dec_unsup}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> !(dec_valid || dec_invalid || dec_unsup));

    p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_size != 2'd3);

    p_clip16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_size == 2'd1) |-> dec_imm[31:16] == 16'd0);

    p_clip8_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_size == 2'd0) |-> dec_imm[31:8] == 24'd0);

    p_noimm_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_has_imm) |-> dec_imm == 32'd0);

    p_acc_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accum) |-> (dec_has_imm && dec_rm_first && dec_rm_sel == 3'd0));

endmodule

bind cmp_stream_decoder cmpdec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .dec_valid    (dec_valid),
    .dec_invalid  (dec_invalid),
    .dec_unsup    (dec_unsup),
    .dec_size     (dec_size),
    .dec_has_imm  (dec_has_imm),
    .dec_imm      (dec_imm),
    .dec_rm_first (dec_rm_first),
    .dec_accum    (dec_accum),
    .dec_rm_sel   (dec_rm_sel)
);

// File: tb/test_cmp_stream_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers queue expected outcomes, a monitor compares.
module test_cmp_stream_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        dec_valid, dec_invalid, dec_unsup;
    logic [1:0]  dec_size;
    logic        dec_has_imm;
    logic [31:0] dec_imm;
    logic        dec_rm_first, dec_accum;
    logic [2:0]  dec_reg_sel, dec_rm_sel;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 record, 1 invalid, 2 unsupported
        int          req;
        logic [1:0]  size;
        logic        has;
        logic [31:0] imm;
        logic        rf;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic        acc;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    cmp_stream_decoder i_cmp_stream_decoder (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .byte_valid(byte_valid), .byte_in(byte_in),
        .dec_valid(dec_valid), .dec_invalid(dec_invalid), .dec_unsup(dec_unsup),
        .dec_size(dec_size), .dec_has_imm(dec_has_imm), .dec_imm(dec_imm),
        .dec_rm_first(dec_rm_first), .dec_accum(dec_accum),
        .dec_reg_sel(dec_reg_sel), .dec_rm_sel(dec_rm_sel)
    );

    task automatic expect_rec(input int req, input logic [1:0] sz, input logic has,
                              input logic [31:0] imm, input logic rf,
                              input logic [2:0] rg, input logic [2:0] rm, input logic acc);
        exp_t e;
        e.kind = 0; e.req = req; e.size = sz; e.has = has; e.imm = imm;
        e.rf = rf; e.rg = rg; e.rm = rm; e.acc = acc;
        exp_q.push_back(e);
    endtask

    task automatic expect_kind(input int req, input int kind);
        exp_t e;
        e.kind = kind; e.req = req; e.size = '0; e.has = 1'b0; e.imm = '0;
        e.rf = 1'b0; e.rg = '0; e.rm = '0; e.acc = 1'b0;
        exp_q.push_back(e);
    endtask

    task automatic put(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        byte_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_in = 8'h3C ^ 8'(i);   // junk that would look like an opcode
            @(negedge clk);
        end
    endtask

    task automatic check_idle_outputs(input string tag);
        tests++;
        if (dec_valid || dec_invalid || dec_unsup || dec_size != 0 || dec_has_imm ||
            dec_imm != 0 || dec_rm_first || dec_accum || dec_reg_sel != 0 || dec_rm_sel != 0) begin
            fails++;
            $display("FAIL %s reset outputs: got v=%0b i=%0b u=%0b imm=%h, expected all zero",
                     tag, dec_valid, dec_invalid, dec_unsup, dec_imm);
        end
    endtask

    // Monitor: pop one expected item per outcome pulse and compare
    always @(negedge clk) begin
        if (rst_n && !done && (dec_valid || dec_invalid || dec_unsup)) begin
            int   kind;
            exp_t e;
            kind = dec_valid ? 0 : (dec_invalid ? 1 : 2);
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected outcome kind=%0d, expected none", kind);
            end else begin
                e = exp_q.pop_front();
                if (kind != e.kind) begin
                    fails++;
                    $display("FAIL R%0d outcome kind: got %0d expected %0d", e.req, kind, e.kind);
                end else if (kind == 0 &&
                    (dec_size != e.size || dec_has_imm != e.has || dec_imm != e.imm ||
                     dec_rm_first != e.rf || dec_reg_sel != e.rg || dec_rm_sel != e.rm ||
                     dec_accum != e.acc)) begin
                    fails++;
                    $display("FAIL R%0d record: got sz=%0d has=%0b imm=%h rf=%0b reg=%0d rm=%0d acc=%0b expected sz=%0d has=%0b imm=%h rf=%0b reg=%0d rm=%0d acc=%0b",
                             e.req, dec_size, dec_has_imm, dec_imm, dec_rm_first, dec_reg_sel,
                             dec_rm_sel, dec_accum, e.size, e.has, e.imm, e.rf, e.rg, e.rm, e.acc);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle_outputs("R1");          // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);

        // R2: accumulator byte form
        expect_rec(2, 2'd0, 1, 32'h0000007F, 1, 3'd0, 3'd0, 1);
        put(8'h3C); put(8'h7F);

        // R3: accumulator full width, 32-bit then 16-bit
        wide_mode = 1'b1;
        expect_rec(3, 2'd2, 1, 32'h12345678, 1, 3'd0, 3'd0, 1);
        put(8'h3D); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
        wide_mode = 1'b0;
        expect_rec(3, 2'd1, 1, 32'h0000ABCD, 1, 3'd0, 3'd0, 1);
        put(8'h3D); put(8'hCD); put(8'hAB);

        // R4: group forms, reg-reg, ext 7
        expect_rec(4, 2'd0, 1, 32'h00000080, 1, 3'd0, 3'd3, 0);
        put(8'h80); put(8'hFB); put(8'h80);
        wide_mode = 1'b1;
        expect_rec(4, 2'd2, 1, 32'h84030201, 1, 3'd0, 3'd1, 0);
        put(8'h81); put(8'hF9); put(8'h01); put(8'h02); put(8'h03); put(8'h84);
        wide_mode = 1'b0;
        expect_rec(4, 2'd1, 1, 32'h00001234, 1, 3'd0, 3'd6, 0);
        put(8'h81); put(8'hFE); put(8'h34); put(8'h12);

        // R5: short immediate sign extension
        wide_mode = 1'b1;
        expect_rec(5, 2'd2, 1, 32'hFFFFFF80, 1, 3'd0, 3'd7, 0);
        put(8'h83); put(8'hFF); put(8'h80);
        wide_mode = 1'b0;
        expect_rec(5, 2'd1, 1, 32'h0000FFF0, 1, 3'd0, 3'd0, 0);
        put(8'h83); put(8'hF8); put(8'hF0);
        wide_mode = 1'b1;
        expect_rec(5, 2'd2, 1, 32'h0000007F, 1, 3'd0, 3'd2, 0);
        put(8'h83); put(8'hFA); put(8'h7F);

        // R6 and R11: register-register forms, no immediate
        expect_rec(6, 2'd0, 0, 32'h0, 1, 3'd1, 3'd0, 0);
        put(8'h38); put(8'hC8);
        expect_rec(6, 2'd2, 0, 32'h0, 1, 3'd2, 3'd3, 0);
        put(8'h39); put(8'hD3);
        expect_rec(6, 2'd0, 0, 32'h0, 0, 3'd4, 3'd5, 0);
        put(8'h3A); put(8'hE5);
        wide_mode = 1'b0;
        expect_rec(11, 2'd1, 0, 32'h0, 0, 3'd7, 3'd7, 0);
        put(8'h3B); put(8'hFF);

        // R7: wrong group extension, then recovery
        expect_kind(7, 1);
        put(8'h80); put(8'hC3);
        expect_kind(7, 1);
        put(8'h81); put(8'hE8);
        expect_rec(7, 2'd0, 1, 32'h00000001, 1, 3'd0, 3'd0, 1);
        put(8'h3C); put(8'h01);

        // R8: foreign opcodes
        expect_kind(8, 1);
        put(8'h90);
        expect_kind(8, 1);
        put(8'h3E);
        expect_rec(8, 2'd0, 0, 32'h0, 1, 3'd5, 3'd6, 0);
        put(8'h38); put(8'hEE);

        // R9: memory-form ModRM
        expect_kind(9, 2);
        put(8'h39); put(8'h03);
        expect_kind(9, 2);
        put(8'h83); put(8'h78);
        expect_rec(9, 2'd0, 1, 32'h00000022, 1, 3'd0, 3'd0, 1);
        put(8'h3C); put(8'h22);

        // R10 and R3: idle gaps, mode captured with opcode only
        gap(2);
        wide_mode = 1'b1;
        expect_rec(10, 2'd2, 1, 32'h44332211, 1, 3'd0, 3'd0, 1);
        put(8'h3D); put(8'h11); gap(3);
        wide_mode = 1'b0;
        put(8'h22); gap(1); put(8'h33); put(8'h44);
        gap(3);

        // R1: reset in the middle of an immediate
        wide_mode = 1'b1;
        put(8'h3D); put(8'h55);
        byte_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check_idle_outputs("R1");
        rst_n = 1'b1;
        expect_rec(1, 2'd0, 1, 32'h00000066, 1, 3'd0, 3'd0, 1);
        put(8'h3C); put(8'h66);
        gap(5);

        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing outcomes: got %0d left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule